// File: doc/BRIEF.md
# Video Raster Timing Generator with Early Fetch Strobe

This block produces the timing skeleton of a video raster: horizontal and vertical sync, a data-enable window, a 1-based line counter and a frame counter. Every line and every frame are built from four programmed spans in a fixed order: sync pulse, back porch, active region, front porch. The engine is started and stopped by a single enable level. A stop request waits for the end of the current frame, and a running flag shows whether the raster is really being produced.

For the pixel pipeline, the block issues a one-cycle fetch strobe. It is placed at an absolute pixel count measured from the first pixel of the vertical sync, so fetching for the next frame can begin inside the vertical front porch. Once that window has been entered, a second frame-count output already reports the coming frame. An underrun strobe flags a frame whose first active pixel arrives while the pipeline has not signalled that it is ready.

Configuration inputs are copied into a shadow register while the engine is stopped and at every frame boundary. Mid-frame changes to them therefore never tear a frame.

Top module: `raster_timer`

## Requirements
- R1: Each line lasts hsw+hbp+hact+hfp pixel clocks. The unpolarised horizontal sync is active on the first hsw pixels of the line. de_o is high only on the hact pixels that follow hsw+hbp pixels, and only on active lines.
- R2: Each frame lasts vsw+vbp+vact+vfp lines. The unpolarised vertical sync is active on the first vsw lines. Active lines are the vact lines that follow vsw+vbp lines.
- R3: A polarity bit of 1 inverts its sync output. While the engine is stopped, both sync outputs rest at their inactive level, which equals the polarity bit.
- R4: line_o is 1 on the first vsync line and counts up by one per line while running, and it reads 0 while stopped. frame_o increases by one (modulo 2^FCW) at the first pixel of every frame, including the first frame after a start.
- R5: When prefetch is enabled, fetch_o pulses for one cycle at the pixel whose count from the start of vsync equals the programmed start value, where 1 is the first vsync pixel. It never pulses when prefetch is disabled.
- R6: While running with prefetch enabled, frame_rep_o equals frame_o+1 whenever line_o is greater than (vertical total − vfp) and at most the vertical total. Otherwise it equals frame_o.
- R7: When en_i is seen high while stopped, the next cycle shows running_o high, the raster at the first pixel of vsync, and vsync_evt_o high.
- R8: A low en_i while running is remembered, even if en_i returns high. The engine keeps running until the last pixel of the frame, and running_o falls on the following cycle, together with a one-cycle vsync_evt_o. vsync_evt_o also pulses on the first pixel of every frame that follows without a stop.
- R9: underrun_o pulses on the first active pixel of a frame if fetch_rdy_i is low in that cycle.
- R10: The configuration inputs (spans, polarities, prefetch enable and start value) take effect only from the next frame while running. While stopped, they are taken one cycle after they are applied.
- R11: After reset the engine is stopped: running_o, de_o, fetch_o, underrun_o and vsync_evt_o are low, line_o and frame_o are 0, and both syncs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run request level |
| hsw_i | input | HW | Horizontal sync width in pixels (≥1) |
| hbp_i | input | HW | Horizontal back porch in pixels (≥1) |
| hact_i | input | HW | Active pixels per line (≥1) |
| hfp_i | input | HW | Horizontal front porch in pixels (≥1) |
| vsw_i | input | VW | Vertical sync width in lines (≥1) |
| vbp_i | input | VW | Vertical back porch in lines (≥1) |
| vact_i | input | VW | Active lines per frame (≥1) |
| vfp_i | input | VW | Vertical front porch in lines (≥1) |
| hpol_i | input | 1 | Horizontal sync polarity, 1 inverts |
| vpol_i | input | 1 | Vertical sync polarity, 1 inverts |
| pf_en_i | input | 1 | Prefetch enable |
| pf_start_i | input | FW | Fetch strobe position, pixels from vsync start (1 = first) |
| fetch_rdy_i | input | 1 | Pixel pipeline ready for active video |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| line_o | output | VW+2 | 1-based line counter, 0 when stopped |
| frame_o | output | FCW | Frame counter |
| frame_rep_o | output | FCW | Frame count including a frame already being fetched |
| vsync_evt_o | output | 1 | Frame boundary event |
| fetch_o | output | 1 | Fetch start strobe |
| underrun_o | output | 1 | Active video began without fetch_rdy_i |
| running_o | output | 1 | Engine is producing a raster |

## Verification
The bench builds the block with HW=6, VW=6, FW=12 and FCW=4. With these values, frames of 150 and 30 pixels can be run in large numbers, and a sixteen-frame run carries both frame_o and frame_rep_o through their wrap. A fetch start of 1 exercises the very first vsync pixel, and a start deep in the front porch opens the early-count window. Mid-frame changes to the configuration, a stop request that is withdrawn before the boundary, and a fetch-ready drop at the first active pixel all happen at the exact cycles where a wrong register stage would show.

// File: rtl/raster_pkg.sv
// Shared definitions for the raster timing generator.
// Assumes: nothing beyond IEEE 1800-2017.
package raster_pkg;

    // Run-control states: stopped, producing frames, finishing last frame
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_RUN   = 2'd1,
        RS_DRAIN = 2'd2
    } run_state_e;

endpackage

// File: rtl/raster_shadow.sv
// Shadow copy of the packed configuration word.
// Assumes: load is high only when the engine is stopped or at a frame end.
module raster_shadow #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] cfg_in,
    output logic [CW-1:0] cfg_q
);

    // Capture the live configuration when allowed
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (load)
            cfg_q <= cfg_in;
    end

endmodule

// File: rtl/raster_axis.sv
// One raster axis: position counter plus region decode for the
// order sync, back porch, active, front porch.
// Assumes: every span is at least 1; step advances by one position.
module raster_axis #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         step,
    input  logic [W-1:0] sw,
    input  logic [W-1:0] bp,
    input  logic [W-1:0] act,
    input  logic [W-1:0] fp,
    output logic [W+1:0] pos,
    output logic [W+1:0] tot,
    output logic         last,
    output logic         in_sync,
    output logic         in_act,
    output logic         at_act_start
);

    localparam int TW = W + 2;

    logic [TW-1:0] act_beg;
    logic [TW-1:0] act_end;

    // Span boundaries derived from the programmed widths
    always_comb begin
        act_beg = TW'(sw) + TW'(bp);
        act_end = act_beg + TW'(act);
        tot     = act_end + TW'(fp);
    end

    // Region flags for the current position
    always_comb begin
        last         = (pos == tot - TW'(1));
        in_sync      = (pos < TW'(sw));
        in_act       = (pos >= act_beg) && (pos < act_end);
        at_act_start = (pos == act_beg);
    end

    // Position counter, held at zero while restart is high
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (restart)
            pos <= '0;
        else if (step)
            pos <= last ? '0 : pos + TW'(1);
    end

endmodule

// File: rtl/raster_ctrl.sv
// Run control: start on enable, stop only at frame end, frame and
// vsync-relative pixel counters, frame boundary event.
// Assumes: h_last/v_last come from the axis counters of this engine.
module raster_ctrl
    import raster_pkg::*;
#(
    parameter int FW  = 16,
    parameter int FCW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic           h_last,
    input  logic           v_last,
    output logic           running,
    output logic           frame_end,
    output logic           cfg_load,
    output logic [FW-1:0]  pix,
    output logic [FCW-1:0] frame,
    output logic           evt
);

    run_state_e state_q;
    logic       start;
    logic       advance;

    // Decode the boundary conditions of the current cycle
    always_comb begin
        running   = (state_q != RS_IDLE);
        frame_end = running && h_last && v_last;
        start     = (state_q == RS_IDLE) && en_i;
        advance   = start || (frame_end && (state_q == RS_RUN) && en_i);
        cfg_load  = !running || frame_end;
    end

    // Run state: a stop request is sticky until the frame ends
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RS_IDLE;
        else begin
            case (state_q)
                RS_IDLE:  if (en_i) state_q <= RS_RUN;
                RS_RUN:   if (!en_i) state_q <= frame_end ? RS_IDLE : RS_DRAIN;
                RS_DRAIN: if (frame_end) state_q <= RS_IDLE;
                default:  state_q <= RS_IDLE;
            endcase
        end
    end

    // Pixel count from first vsync pixel, 1-based
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix <= FW'(1);
        else if (!running || frame_end)
            pix <= FW'(1);
        else
            pix <= pix + FW'(1);
    end

    // Frame counter and frame boundary event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '0;
            evt   <= 1'b0;
        end else begin
            if (advance)
                frame <= frame + FCW'(1);
            evt <= start || frame_end;
        end
    end

endmodule

// File: rtl/raster_timer.sv
// Top of the raster timing generator with early fetch strobe.
// Assumes: all spans at least 1; outputs are decoded from registered
// counters, so they belong to the pixel the counters point at.
module raster_timer #(
    parameter int HW  = 12,
    parameter int VW  = 12,
    parameter int FW  = 24,
    parameter int FCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic [HW-1:0]  hsw_i,
    input  logic [HW-1:0]  hbp_i,
    input  logic [HW-1:0]  hact_i,
    input  logic [HW-1:0]  hfp_i,
    input  logic [VW-1:0]  vsw_i,
    input  logic [VW-1:0]  vbp_i,
    input  logic [VW-1:0]  vact_i,
    input  logic [VW-1:0]  vfp_i,
    input  logic           hpol_i,
    input  logic           vpol_i,
    input  logic           pf_en_i,
    input  logic [FW-1:0]  pf_start_i,
    input  logic           fetch_rdy_i,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic           de_o,
    output logic [VW+1:0]  line_o,
    output logic [FCW-1:0] frame_o,
    output logic [FCW-1:0] frame_rep_o,
    output logic           vsync_evt_o,
    output logic           fetch_o,
    output logic           underrun_o,
    output logic           running_o
);

    localparam int CW  = 4*HW + 4*VW + 3 + FW;
    localparam int VTW = VW + 2;

    logic [CW-1:0]  cfg_live, cfg_q;
    logic [HW-1:0]  s_hsw, s_hbp, s_hact, s_hfp;
    logic [VW-1:0]  s_vsw, s_vbp, s_vact, s_vfp;
    logic           s_hpol, s_vpol, s_pf_en;
    logic [FW-1:0]  s_pf_start;

    logic           running, frame_end, cfg_load, evt;
    logic [FW-1:0]  pix;
    logic [FCW-1:0] frame;

    logic [HW+1:0]  h_pos, h_tot;
    logic [VTW-1:0] v_pos, v_tot;
    logic           h_last, h_sync, h_act, h_first;
    logic           v_last, v_sync, v_act, v_first;
    logic           rep_win;

    // Pack live configuration and unpack the shadow copy
    assign cfg_live = {hsw_i, hbp_i, hact_i, hfp_i, vsw_i, vbp_i, vact_i, vfp_i,
                       hpol_i, vpol_i, pf_en_i, pf_start_i};
    assign {s_hsw, s_hbp, s_hact, s_hfp, s_vsw, s_vbp, s_vact, s_vfp,
            s_hpol, s_vpol, s_pf_en, s_pf_start} = cfg_q;

    raster_shadow #(.CW(CW)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cfg_load),
        .cfg_in (cfg_live),
        .cfg_q  (cfg_q)
    );

    raster_ctrl #(.FW(FW), .FCW(FCW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .h_last    (h_last),
        .v_last    (v_last),
        .running   (running),
        .frame_end (frame_end),
        .cfg_load  (cfg_load),
        .pix       (pix),
        .frame     (frame),
        .evt       (evt)
    );

    raster_axis #(.W(HW)) u_hax (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (!running),
        .step         (running),
        .sw           (s_hsw),
        .bp           (s_hbp),
        .act          (s_hact),
        .fp           (s_hfp),
        .pos          (h_pos),
        .tot          (h_tot),
        .last         (h_last),
        .in_sync      (h_sync),
        .in_act       (h_act),
        .at_act_start (h_first)
    );

    raster_axis #(.W(VW)) u_vax (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (!running),
        .step         (running && h_last),
        .sw           (s_vsw),
        .bp           (s_vbp),
        .act          (s_vact),
        .fp           (s_vfp),
        .pos          (v_pos),
        .tot          (v_tot),
        .last         (v_last),
        .in_sync      (v_sync),
        .in_act       (v_act),
        .at_act_start (v_first)
    );

    // Raster outputs decoded from the counter position
    always_comb begin
        hsync_o    = (running && h_sync) ^ s_hpol;
        vsync_o    = (running && v_sync) ^ s_vpol;
        de_o       = running && h_act && v_act;
        line_o     = running ? v_pos + VTW'(1) : '0;
        fetch_o    = running && s_pf_en && (pix == s_pf_start);
        underrun_o = running && h_first && v_first && !fetch_rdy_i;
    end

    // Frame count that already includes a frame being fetched
    always_comb begin
        rep_win     = running && s_pf_en && (line_o > v_tot - VTW'(s_vfp))
                      && (line_o <= v_tot);
        frame_rep_o = rep_win ? frame + FCW'(1) : frame;
        frame_o     = frame;
        vsync_evt_o = evt;
        running_o   = running;
    end

endmodule

// File: rtl/raster_timer_chk.sv
// Property checker for raster_timer, attached by bind.
// Assumes: synchronous active-low reset held for at least one edge.
module raster_timer_chk #(
    parameter int VW  = 12,
    parameter int FCW = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fetch_rdy_i,
    input logic           de_o,
    input logic [VW+1:0]  line_o,
    input logic [FCW-1:0] frame_o,
    input logic [FCW-1:0] frame_rep_o,
    input logic           vsync_evt_o,
    input logic           fetch_o,
    input logic           underrun_o,
    input logic           running_o
);

    p_de_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> !de_o);

    p_line_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |-> (line_o != '0));

    p_frame_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && $past(running_o) && !vsync_evt_o) |-> $stable(frame_o));

    p_fetch_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> running_o);

    p_rep_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_rep_o == frame_o) || (frame_rep_o == FCW'(frame_o + FCW'(1))));

    p_start_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_o) |-> (vsync_evt_o && line_o == (VW+2)'(1)));

    p_stop_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> vsync_evt_o);

    p_underrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> (de_o && !fetch_rdy_i));

endmodule

bind raster_timer raster_timer_chk #(.VW(VW), .FCW(FCW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_rdy_i (fetch_rdy_i),
    .de_o        (de_o),
    .line_o      (line_o),
    .frame_o     (frame_o),
    .frame_rep_o (frame_rep_o),
    .vsync_evt_o (vsync_evt_o),
    .fetch_o     (fetch_o),
    .underrun_o  (underrun_o),
    .running_o   (running_o)
);

// File: tb/sim_raster_timer.sv
// Scoreboard bench: a reference model pushes expected outputs per pixel,
// a monitor pops them and compares with the design.
module sim_raster_timer;

    localparam int HW = 6, VW = 6, FW = 12, FCW = 4;
    localparam int FMOD = 1 << FCW;

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
    logic [HW-1:0] hsw, hbp, hact, hfp;
    logic [VW-1:0] vsw, vbp, vact, vfp;
    logic hpol, vpol, pf_en, fetch_rdy;
    logic [FW-1:0] pf_start;
    logic hsync, vsync, de, evt, fetch, underrun, running;
    logic [VW+1:0] line;
    logic [FCW-1:0] frame, frame_rep;

    always #2 clk = ~clk;

    raster_timer #(.HW(HW), .VW(VW), .FW(FW), .FCW(FCW)) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en),
        .hsw_i(hsw), .hbp_i(hbp), .hact_i(hact), .hfp_i(hfp),
        .vsw_i(vsw), .vbp_i(vbp), .vact_i(vact), .vfp_i(vfp),
        .hpol_i(hpol), .vpol_i(vpol), .pf_en_i(pf_en), .pf_start_i(pf_start),
        .fetch_rdy_i(fetch_rdy),
        .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .line_o(line),
        .frame_o(frame), .frame_rep_o(frame_rep), .vsync_evt_o(evt),
        .fetch_o(fetch), .underrun_o(underrun), .running_o(running)
    );

    typedef struct {
        int hsync, vsync, de, line, frame, rep, evt, fetch, und, run;
    } exp_t;

    typedef struct {
        int hsw, hbp, hact, hfp, vsw, vbp, vact, vfp, hpol, vpol, pfen, pfs;
    } cfg_t;

    exp_t  sb_q[$];
    int    n_chk = 0, n_fail = 0;
    string ph = "R7";
    cfg_t  mc;
    int    m_run = 0, m_stop = 0, m_h = 0, m_v = 0, m_pix = 1, m_frame = 0, m_evt = 0;

    function automatic cfg_t live_cfg();
        cfg_t c;
        c.hsw = hsw; c.hbp = hbp; c.hact = hact; c.hfp = hfp;
        c.vsw = vsw; c.vbp = vbp; c.vact = vact; c.vfp = vfp;
        c.hpol = hpol; c.vpol = vpol; c.pfen = pf_en; c.pfs = pf_start;
        return c;
    endfunction

    // Reference model of the requirements, advanced on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            mc = '{default: 0};
            m_run = 0; m_stop = 0; m_h = 0; m_v = 0; m_pix = 1; m_frame = 0; m_evt = 0;
        end else begin
            int ht, vt, fend, start, stopnow, nstop;
            ht = mc.hsw + mc.hbp + mc.hact + mc.hfp;
            vt = mc.vsw + mc.vbp + mc.vact + mc.vfp;
            fend    = (m_run != 0 && m_h == ht-1 && m_v == vt-1) ? 1 : 0;
            start   = (m_run == 0 && en) ? 1 : 0;
            stopnow = (fend != 0 && (m_stop != 0 || !en)) ? 1 : 0;
            nstop   = (m_run != 0 && fend == 0 && (m_stop != 0 || !en)) ? 1 : 0;
            if (m_run == 0 || fend != 0) mc = live_cfg();
            m_evt = (start != 0 || fend != 0) ? 1 : 0;
            if (start != 0) begin
                m_run = 1; m_frame = (m_frame + 1) % FMOD; m_h = 0; m_v = 0; m_pix = 1;
            end else if (m_run == 0) begin
                m_h = 0; m_v = 0; m_pix = 1;
            end else if (fend != 0) begin
                m_h = 0; m_v = 0; m_pix = 1;
                if (stopnow != 0) m_run = 0;
                else m_frame = (m_frame + 1) % FMOD;
            end else begin
                m_pix++;
                if (m_h == ht-1) begin m_h = 0; m_v++; end
                else m_h++;
            end
            m_stop = nstop;
        end
    end

    // Predictor: push the expected outputs of this pixel
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            int vt, hb, vb;
            vt = mc.vsw + mc.vbp + mc.vact + mc.vfp;
            hb = mc.hsw + mc.hbp;
            vb = mc.vsw + mc.vbp;
            e.run   = m_run;
            e.hsync = ((m_run != 0 && m_h < mc.hsw) ? 1 : 0) ^ mc.hpol;
            e.vsync = ((m_run != 0 && m_v < mc.vsw) ? 1 : 0) ^ mc.vpol;
            e.de    = (m_run != 0 && m_h >= hb && m_h < hb + mc.hact
                       && m_v >= vb && m_v < vb + mc.vact) ? 1 : 0;
            e.line  = (m_run != 0) ? m_v + 1 : 0;
            e.frame = m_frame;
            e.rep   = (m_run != 0 && mc.pfen != 0 && e.line > vt - mc.vfp && e.line <= vt)
                      ? (m_frame + 1) % FMOD : m_frame;
            e.evt   = m_evt;
            e.fetch = (m_run != 0 && mc.pfen != 0 && m_pix == mc.pfs) ? 1 : 0;
            e.und   = (m_run != 0 && m_h == hb && m_v == vb && !fetch_rdy) ? 1 : 0;
            sb_q.push_back(e);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (%s) t=%0t act=%0d exp=%0d", req, ph, $time, act, exp);
        end
    endtask

    // Monitor: pop expected items and compare with the design
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk("R7 running", int'(running), e.run);
            chk("R1/R3 hsync", int'(hsync), e.hsync);
            chk("R2/R3 vsync", int'(vsync), e.vsync);
            chk("R1/R2 de", int'(de), e.de);
            chk("R4 line", int'(line), e.line);
            chk("R4 frame", int'(frame), e.frame);
            chk("R6 frame_rep", int'(frame_rep), e.rep);
            chk("R8 vsync_evt", int'(evt), e.evt);
            chk("R5 fetch", int'(fetch), e.fetch);
            chk("R9 underrun", int'(underrun), e.und);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cfg_a();
        hsw = 2; hbp = 3; hact = 6; hfp = 4;
        vsw = 1; vbp = 2; vact = 4; vfp = 3;
        hpol = 0; vpol = 0; pf_en = 1; pf_start = 12'd121;
    endtask

    task automatic cfg_b();
        hsw = 1; hbp = 1; hact = 3; hfp = 1;
        vsw = 1; vbp = 1; vact = 2; vfp = 1;
        hpol = 1; vpol = 0; pf_en = 1; pf_start = 12'd1;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Driver: stimulus sequence
    initial begin
        cfg_a();
        fetch_rdy = 1;
        cyc(3);
        @(negedge clk);
        // R11: reset state
        chk("R11 running", int'(running), 0);
        chk("R11 de", int'(de), 0);
        chk("R11 line", int'(line), 0);
        chk("R11 frame", int'(frame), 0);
        chk("R11 hsync", int'(hsync), 0);
        chk("R11 vsync", int'(vsync), 0);
        chk("R11 evt", int'(evt), 0);
        cyc(1);
        rst_n = 1;
        cyc(4);
        ph = "R7"; en = 1; cyc(300);
        ph = "R10"; cyc(40); hact = 5; hpol = 1; vbp = 1; cyc(320);
        ph = "R9"; fetch_rdy = 0; cyc(150); fetch_rdy = 1;
        ph = "R5"; pf_en = 0; cyc(150); pf_en = 1; pf_start = 12'd60; cyc(150);
        ph = "R8"; en = 0; cyc(200);
        ph = "R3"; vpol = 1; cyc(10);
        ph = "R8"; en = 1; cyc(20); en = 0; cyc(5); en = 1; cyc(200); en = 0; cyc(160);
        ph = "R4"; cfg_b(); cyc(2); en = 1; cyc(30 * 18);
        ph = "R8"; en = 0; cyc(60);
        @(negedge clk); #2;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule